// File: doc/BRIEF.md
# Imprecise Abort Fault Capture Unit

This block keeps a diagnostic record of the bus aborts that are reported to a CPU. Each abort event comes from the bus fabric with four pieces of information: a flag that says whether it is precise or imprecise, the faulting address, the identifier of the bus master that caused it, and a one-hot region flag. Writes from DMA, memory-mover or peripheral bus masters into the peripheral or external-memory regions end as imprecise aborts. The master identifier then tells software which master was responsible.

Two read-only registers show what was captured. The status word holds the abort-type flag in bit 0, the master identifier and the region flags. The fault address register holds the full 32-bit address. After an imprecise abort is captured, the record is locked, and later aborts are ignored until software reads the status word. That read clears the flag.

The unit has two resets. Power-on reset clears the record. A warm reset only clears the read-data path, so the record stays available after the system restarts.

Top module: `abort_capture_unit`

## Requirements
- R1: On an accepted abort, bit 0 of the status word (the abort-type flag) becomes 1 if the abort is imprecise and 0 if it is precise.
- R2: An accepted precise abort leaves the master identifier, the region flags and the fault address unchanged.
- R3: An accepted imprecise abort captures its master identifier into status bits 15:8 and its region flags into status bits 18:16 (bit 16 peripheral bus, bit 17 non-cacheable region, bit 18 external memory). It also captures its address into the fault address register. All other status bits read 0.
- R4: A read of the status word (offset 0xA8) clears the abort-type flag. The master identifier, region flags and fault address keep their values.
- R5: While the abort-type flag is 1, abort events change neither the status word nor the fault address, unless the same cycle carries a status read.
- R6: If an abort arrives in the same cycle as a status read, the read returns the old contents, and the new abort is then captured as if the flag were already clear.
- R7: The fault address register is read at offset 0xAC. It changes only when an imprecise abort is captured.
- R8: A warm reset keeps the captured record unchanged. While the warm reset is active, the read data is 0.
- R9: A power-on reset clears the abort-type flag, the capture fields and the fault address to 0.
- R10: A read of any offset other than 0xA8 or 0xAC returns 0. The read data is also 0 in any cycle that follows a cycle without a read.
- R11: Writes to any offset have no effect on the record.
- R12: Read data appears one clock after the read request is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| warm_rst_n | input | 1 | Warm reset, active low, asynchronous; clears only the read-data path |
| abort_valid | input | 1 | Abort event strobe from the bus fabric |
| abort_imprecise | input | 1 | 1 = imprecise abort, 0 = precise abort |
| abort_addr | input | 32 | Faulting address of the event |
| abort_master | input | 8 | Identifier of the bus master that caused the event |
| abort_region | input | 3 | One-hot region: bit 0 peripheral, bit 1 non-cacheable, bit 2 external memory |
| reg_ofs | input | 8 | Byte offset for a register read or write |
| rd_en | input | 1 | Register read request |
| wr_en | input | 1 | Register write request (ignored) |
| wr_data | input | 32 | Register write data (ignored) |
| rd_data | output | 32 | Read data, valid one clock after the request |

## Verification
Each stimulus is applied at a falling edge and takes effect at the next rising edge. The read data for a request sampled at that rising edge is checked at the falling edge that follows it. That read data reflects the record as it stood before the edge, which gives the old-contents result when an abort and a status read share a cycle. The effect of an abort or a clear is therefore never checked in the same step. It is only seen through a later read, one full cycle after the event. The warm-reset and write cases are observed the same way: with extra reads after the stimulus ends.

// File: rtl/acu_pkg.sv
package acu_pkg;
  localparam int MID_W    = 8;
  localparam int REGION_W = 3;
  localparam int DATA_W   = 32;

  localparam int STAT_TYPE_BIT = 0;
  localparam int STAT_MID_LSB  = 8;
  localparam int STAT_REG_LSB  = 16;

  function automatic logic [DATA_W-1:0] pack_status(
      input logic                imp_flag,
      input logic [MID_W-1:0]    mid,
      input logic [REGION_W-1:0] region);
    logic [DATA_W-1:0] w;
    w = '0;
    w[STAT_TYPE_BIT] = imp_flag;
    w[STAT_MID_LSB +: MID_W] = mid;
    w[STAT_REG_LSB +: REGION_W] = region;
    return w;
  endfunction
endpackage

// File: rtl/acu_capture.sv
module acu_capture
  import acu_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                clk,
  input  logic                por_n,
  input  logic                ev_valid,
  input  logic                ev_imprecise,
  input  logic [ADDR_W-1:0]   ev_addr,
  input  logic [MID_W-1:0]    ev_master,
  input  logic [REGION_W-1:0] ev_region,
  input  logic                clr_req,
  output logic                type_o,
  output logic [MID_W-1:0]    master_o,
  output logic [REGION_W-1:0] region_o,
  output logic [ADDR_W-1:0]   addr_o
);
  logic                type_q;
  logic [MID_W-1:0]    master_q;
  logic [REGION_W-1:0] region_q;
  logic [ADDR_W-1:0]   addr_q;

  logic accept;
  logic take_imp;
  assign accept   = ev_valid && (!type_q || clr_req);
  assign take_imp = accept && ev_imprecise;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      type_q   <= 1'b0;
      master_q <= '0;
      region_q <= '0;
      addr_q   <= '0;
    end else begin
      if (accept)       type_q <= ev_imprecise;
      else if (clr_req) type_q <= 1'b0;
      if (take_imp) begin
        master_q <= ev_master;
        region_q <= ev_region;
        addr_q   <= ev_addr;
      end
    end
  end

  assign type_o   = type_q;
  assign master_o = master_q;
  assign region_o = region_q;
  assign addr_o   = addr_q;

  // R2: a precise abort never disturbs the capture fields
  a_r2_precise_keeps: assert property (@(posedge clk) disable iff (!por_n)
    (ev_valid && !ev_imprecise) |=> ($stable(master_q) && $stable(region_q) && $stable(addr_q)));

  // R4: status read without a new abort leaves the flag low
  a_r4_read_clears: assert property (@(posedge clk) disable iff (!por_n)
    (clr_req && !ev_valid) |=> !type_q);

  // R5: locked record holds while no status read happens
  a_r5_locked: assert property (@(posedge clk) disable iff (!por_n)
    (type_q && !clr_req) |=> ($stable(type_q) && $stable(master_q) && $stable(region_q) && $stable(addr_q)));

  // R6: abort in the clearing cycle is taken
  a_r6_same_cycle: assert property (@(posedge clk) disable iff (!por_n)
    (type_q && clr_req && ev_valid) |=> (type_q == $past(ev_imprecise)));

  // R7: address changes only through an imprecise capture
  a_r7_addr_only_imp: assert property (@(posedge clk) disable iff (!por_n)
    !(ev_valid && ev_imprecise) |=> $stable(addr_q));
endmodule

// File: rtl/acu_regread.sv
module acu_regread
  import acu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 8,
  parameter logic [OFS_W-1:0] STAT_OFS  = 8'hA8,
  parameter logic [OFS_W-1:0] FADDR_OFS = 8'hAC
) (
  input  logic              clk,
  input  logic              rst_any_n,
  input  logic              rd_en,
  input  logic [OFS_W-1:0]  ofs,
  input  logic [DATA_W-1:0] status_word,
  input  logic [ADDR_W-1:0] fault_addr,
  output logic              stat_rd,
  output logic [DATA_W-1:0] rd_data
);
  logic              hit_stat;
  logic              hit_addr;
  logic [DATA_W-1:0] mux_data;
  logic [DATA_W-1:0] rd_q;

  assign hit_stat = (ofs == STAT_OFS);
  assign hit_addr = (ofs == FADDR_OFS);
  assign stat_rd  = rd_en && hit_stat;

  always_comb begin
    mux_data = '0;
    if (hit_stat)      mux_data = status_word;
    else if (hit_addr) mux_data = DATA_W'(fault_addr);
  end

  always_ff @(posedge clk or negedge rst_any_n) begin
    if (!rst_any_n) rd_q <= '0;
    else            rd_q <= rd_en ? mux_data : '0;
  end

  assign rd_data = rd_q;

  // R10: undefined offsets and idle cycles read as zero
  a_r10_undef_zero: assert property (@(posedge clk) disable iff (!rst_any_n)
    !(rd_en && (hit_stat || hit_addr)) |=> (rd_data == '0));

  // R12: status read returns the pre-edge status one cycle later
  a_r12_latency: assert property (@(posedge clk) disable iff (!rst_any_n)
    stat_rd |=> (rd_data == $past(status_word)));
endmodule

// File: rtl/abort_capture_unit.sv
module abort_capture_unit
  import acu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 8,
  parameter logic [OFS_W-1:0] STAT_OFS  = 8'hA8,
  parameter logic [OFS_W-1:0] FADDR_OFS = 8'hAC
) (
  input  logic                clk,
  input  logic                por_n,
  input  logic                warm_rst_n,
  input  logic                abort_valid,
  input  logic                abort_imprecise,
  input  logic [ADDR_W-1:0]   abort_addr,
  input  logic [MID_W-1:0]    abort_master,
  input  logic [REGION_W-1:0] abort_region,
  input  logic [OFS_W-1:0]    reg_ofs,
  input  logic                rd_en,
  input  logic                wr_en,
  input  logic [DATA_W-1:0]   wr_data,
  output logic [DATA_W-1:0]   rd_data
);
  logic                rst_any_n;
  logic                stat_rd;
  logic                cap_type;
  logic [MID_W-1:0]    cap_master;
  logic [REGION_W-1:0] cap_region;
  logic [ADDR_W-1:0]   cap_addr;
  logic [DATA_W-1:0]   status_word;

  assign rst_any_n   = por_n & warm_rst_n;
  assign status_word = pack_status(cap_type, cap_master, cap_region);

  acu_capture #(.ADDR_W(ADDR_W)) u_capture (
    .clk          (clk),
    .por_n        (por_n),
    .ev_valid     (abort_valid),
    .ev_imprecise (abort_imprecise),
    .ev_addr      (abort_addr),
    .ev_master    (abort_master),
    .ev_region    (abort_region),
    .clr_req      (stat_rd),
    .type_o       (cap_type),
    .master_o     (cap_master),
    .region_o     (cap_region),
    .addr_o       (cap_addr)
  );

  acu_regread #(
    .ADDR_W    (ADDR_W),
    .OFS_W     (OFS_W),
    .STAT_OFS  (STAT_OFS),
    .FADDR_OFS (FADDR_OFS)
  ) u_regread (
    .clk         (clk),
    .rst_any_n   (rst_any_n),
    .rd_en       (rd_en),
    .ofs         (reg_ofs),
    .status_word (status_word),
    .fault_addr  (cap_addr),
    .stat_rd     (stat_rd),
    .rd_data     (rd_data)
  );

  // R11: a write on its own leaves the record untouched
  a_r11_write_ignored: assert property (@(posedge clk) disable iff (!por_n)
    (wr_en && (wr_data != '0 || reg_ofs == STAT_OFS) && !abort_valid && !rd_en)
      |=> ($stable(status_word) && $stable(cap_addr)));

  // R8: warm reset alone leaves the record untouched
  a_r8_warm_keeps: assert property (@(posedge clk) disable iff (!por_n)
    (!warm_rst_n && !abort_valid) |=> ($stable(status_word) && $stable(cap_addr)));
endmodule

// File: tb/abort_capture_unit_tb.sv
module abort_capture_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] OFS_STAT  = 8'hA8;
  localparam logic [7:0] OFS_FADDR = 8'hAC;
  localparam int NV = 17;

  // {valid, imprecise, addr, master, region, rd_en, ofs, expected rd_data}
  localparam logic [85:0] VEC [NV] = '{
    {1'b0,1'b0,32'h0,8'h00,3'b000,1'b1,8'hA8,32'h0000_0000},
    {1'b1,1'b1,32'h4000_1230,8'h05,3'b001,1'b0,8'h00,32'h0000_0000},
    {1'b0,1'b0,32'h0,8'h00,3'b000,1'b1,8'hA8,32'h0001_0501},
    {1'b0,1'b0,32'h0,8'h00,3'b000,1'b1,8'hAC,32'h4000_1230},
    {1'b0,1'b0,32'h0,8'h00,3'b000,1'b1,8'hA8,32'h0001_0500},
    {1'b1,1'b0,32'hDEAD_0000,8'h22,3'b100,1'b0,8'h00,32'h0000_0000},
    {1'b0,1'b0,32'h0,8'h00,3'b000,1'b1,8'hA8,32'h0001_0500},
    {1'b0,1'b0,32'h0,8'h00,3'b000,1'b1,8'hAC,32'h4000_1230},
    {1'b1,1'b1,32'h6000_0040,8'h11,3'b100,1'b0,8'h00,32'h0000_0000},
    {1'b1,1'b1,32'h1111_1111,8'h33,3'b010,1'b0,8'h00,32'h0000_0000},
    {1'b1,1'b0,32'h2222_2222,8'h55,3'b001,1'b0,8'h00,32'h0000_0000},
    {1'b0,1'b0,32'h0,8'h00,3'b000,1'b1,8'hAC,32'h6000_0040},
    {1'b1,1'b1,32'h7000_0008,8'h44,3'b010,1'b1,8'hA8,32'h0004_1101},
    {1'b0,1'b0,32'h0,8'h00,3'b000,1'b1,8'hA8,32'h0002_4401},
    {1'b1,1'b0,32'h3333_0000,8'h66,3'b001,1'b1,8'h00,32'h0000_0000},
    {1'b0,1'b0,32'h0,8'h00,3'b000,1'b1,8'hA8,32'h0002_4400},
    {1'b0,1'b0,32'h0,8'h00,3'b000,1'b1,8'hAC,32'h7000_0008}
  };
  // requirement exercised by each vector
  localparam string VREQ [NV] = '{
    "R12", "R10", "R3", "R7", "R4", "R10", "R2", "R2",
    "R1", "R10", "R10", "R5", "R6", "R6", "R10", "R1", "R7"
  };

  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        warm_rst_n = 1'b1;
  logic        abort_valid = 1'b0;
  logic        abort_imprecise = 1'b0;
  logic [31:0] abort_addr = '0;
  logic [7:0]  abort_master = '0;
  logic [2:0]  abort_region = '0;
  logic [7:0]  reg_ofs = '0;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  abort_capture_unit u_dut (
    .clk(clk), .por_n(por_n), .warm_rst_n(warm_rst_n),
    .abort_valid(abort_valid), .abort_imprecise(abort_imprecise),
    .abort_addr(abort_addr), .abort_master(abort_master), .abort_region(abort_region),
    .reg_ofs(reg_ofs), .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data)
  );

  task automatic check(input string req, input logic [31:0] exp);
    checks++;
    if (rd_data !== exp) begin
      errors++;
      $display("FAIL %s: rd_data=%h expected=%h", req, rd_data, exp);
    end
  endtask

  task automatic idle();
    abort_valid = 1'b0; abort_imprecise = 1'b0; rd_en = 1'b0; wr_en = 1'b0;
    reg_ofs = '0; wr_data = '0;
  endtask

  // issue one read after the current negedge, check at the next negedge
  task automatic read_chk(input logic [7:0] ofs, input logic [31:0] exp, input string req);
    idle();
    rd_en = 1'b1; reg_ofs = ofs;
    @(negedge clk);
    check(req, exp);
    idle();
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9", 32'h0);  // reset state
    por_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      {abort_valid, abort_imprecise, abort_addr, abort_master, abort_region,
       rd_en, reg_ofs} = VEC[i][85:32];
      @(negedge clk);
      check(VREQ[i], VEC[i][31:0]);
    end
    idle();

    // R8: warm reset preserves the record, read path reads 0
    abort_valid = 1'b1; abort_imprecise = 1'b1; abort_addr = 32'h2000_0004;
    abort_master = 8'h09; abort_region = 3'b001;
    @(negedge clk);
    idle();
    warm_rst_n = 1'b0;
    rd_en = 1'b1; reg_ofs = OFS_FADDR;
    @(negedge clk);
    check("R8", 32'h0);
    @(negedge clk);
    check("R8", 32'h0);
    idle();
    warm_rst_n = 1'b1;
    @(negedge clk);

    // R11: write of all-zeros to the status word and all-ones to the address
    wr_en = 1'b1; reg_ofs = OFS_STAT; wr_data = 32'h0;
    @(negedge clk);
    wr_en = 1'b1; reg_ofs = OFS_FADDR; wr_data = 32'hFFFF_FFFF;
    @(negedge clk);
    idle();
    read_chk(OFS_FADDR, 32'h2000_0004, "R11");
    read_chk(OFS_STAT, 32'h0001_0901, "R8");

    // R9: power-on reset clears everything
    abort_valid = 1'b1; abort_imprecise = 1'b1; abort_addr = 32'h5555_AAAA;
    abort_master = 8'hEE; abort_region = 3'b100;
    @(negedge clk);
    idle();
    por_n = 1'b0;
    @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
    read_chk(OFS_STAT, 32'h0, "R9");
    read_chk(OFS_FADDR, 32'h0, "R9");

    finish_run();
  end
endmodule